// File: doc/BRIEF.md
# Bootloader Contact Window Timer

After startup this block opens a window in which a host may contact the bootloader. On a start pulse it samples a configuration byte and the stored bit-inverted copy of that byte. It checks the pair against each other and turns the byte into a number of 5 ms units. The unit tick comes from a prescaler on the system clock. The prescaler length is derived at elaboration from the clock frequency and the unit length.

While the window runs, host activity restarts it. A pulse from the passphrase detector freezes it for good, and the block then asks for the watchdog to stop counting. When the window expires, the timeout flag tells the startup sequencer to enter user mode.

Two byte values have a special meaning. Zero closes the window at once. All-ones keeps the window open forever and asks for the watchdog to be switched off.

A second instance, with a larger unit cap, serves as the interframe timeout of the bootloader session. All pins are plain control and status levels or single-cycle pulses. No data flows through the block, so it has no valid/ready handshake.

Top module: `nw_window_timer`

## Requirements
- R1: The tick length is TICK_CYCLES = CLK_FREQ_HZ*TICK_US/1e6 clock cycles. For a valid finite byte n, timeout_o rises exactly n*TICK_CYCLES cycles after the clock edge that sampled start_i. window_open_o is high from that edge until expiry.
- R2: A valid finite byte above MAX_UNITS (default 28, which gives 140 ms) is clamped to MAX_UNITS units.
- R3: A valid byte 8'h00 raises timeout_o in the cycle after the start edge, and window_open_o stays low.
- R4: A valid byte 8'hFF holds window_open_o and wait_forever_o high and never raises timeout_o.
- R5: A pair is valid only when cfg_val_i equals ~cfg_inv_i. Any invalid pair behaves exactly like 8'hFF.
- R6: unlock_i while the window is open stops counting for good. In that case wdog_hold_o goes high, window_open_o stays high, wait_forever_o drops and timeout_o never rises. unlock_i is ignored once the window has expired.
- R7: activity_i while a finite window is counting restarts the full window from that edge. unlock_i takes priority over it. It is ignored once the window has expired.
- R8: start_i restarts the block from any state, clears the prescaler and takes priority over unlock_i and activity_i.
- R9: After reset all outputs are low. timeout_o stays high until the next start_i.
- R10: An instance with MAX_UNITS=254 given byte 8'h38 expires after 56 units (280 ms), and given 8'h80 it expires after 128 units without clamping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; samples the configuration pair |
| cfg_val_i | input | CFG_W | Window length in 5 ms units, or a special code |
| cfg_inv_i | input | CFG_W | Stored bit-inverted copy of the length byte |
| unlock_i | input | 1 | Pulse from the passphrase detector |
| activity_i | input | 1 | Host activity pulse |
| timeout_o | output | 1 | Window expired; enter user mode |
| window_open_o | output | 1 | Window open; keep waiting for the host |
| wait_forever_o | output | 1 | Infinite window; watchdog off requested |
| wdog_hold_o | output | 1 | Window frozen by unlock; watchdog suspend requested |

## Verification
The hardest cases to reach are the exact expiry edge of each length and the handling of a byte above the cap. Only a finite window that runs to its last tick exposes an off-by-one in the prescaler or the unit counter. The stimulus sweeps all 256 bytes with matching inverted copies on a small clock configuration in which one unit lasts five cycles. It samples timeout_o one cycle before and exactly at the computed expiry. Activity and unlock pulses are then placed a known number of cycles into a running window, so the restarted or frozen window can be timed from that edge.

// File: rtl/nw_pkg.sv
package nw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_EXPIRED,
    ST_FOREVER,
    ST_UNLOCKED
  } nw_state_e;

  typedef enum logic [1:0] {
    CFG_CLOSED,
    CFG_FINITE,
    CFG_FOREVER
  } nw_kind_e;

endpackage

// File: rtl/nw_cfg_decode.sv
module nw_cfg_decode import nw_pkg::*; #(
  parameter int unsigned CFG_W     = 8,
  parameter int unsigned MAX_UNITS = 28
) (
  input  logic [CFG_W-1:0] cfg_val,
  input  logic [CFG_W-1:0] cfg_inv,
  output nw_kind_e         kind,
  output logic [CFG_W-1:0] units
);

  localparam logic [CFG_W-1:0] CAP = CFG_W'(MAX_UNITS);

  logic pair_ok;
  logic all_ones;
  logic all_zero;

  assign pair_ok  = (cfg_val == ~cfg_inv);
  assign all_ones = &cfg_val;
  assign all_zero = ~|cfg_val;

  always_comb begin
    units = '0;
    if (!pair_ok || all_ones) begin
      kind = CFG_FOREVER;
    end else if (all_zero) begin
      kind = CFG_CLOSED;
    end else begin
      kind  = CFG_FINITE;
      units = (cfg_val > CAP) ? CAP : cfg_val;
    end
  end

endmodule

// File: rtl/nw_prescaler.sv
module nw_prescaler #(
  parameter int unsigned TICK_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);

  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && !clear && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/nw_unit_counter.sv
module nw_unit_counter #(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] load_val,
  input  logic             dec,
  output logic             last_unit
);

  logic [CFG_W-1:0] remain_q;

  assign last_unit = (remain_q == CFG_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (dec && (remain_q != '0)) begin
      remain_q <= remain_q - 1'b1;
    end
  end

endmodule

// File: rtl/nw_window_timer.sv
module nw_window_timer import nw_pkg::*; #(
  parameter int unsigned CLK_FREQ_HZ = 20_000_000,
  parameter int unsigned TICK_US     = 5000,
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned MAX_UNITS   = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CFG_W-1:0] cfg_val_i,
  input  logic [CFG_W-1:0] cfg_inv_i,
  input  logic             unlock_i,
  input  logic             activity_i,
  output logic             timeout_o,
  output logic             window_open_o,
  output logic             wait_forever_o,
  output logic             wdog_hold_o
);

  localparam longint unsigned TICK_RAW =
    (longint'(CLK_FREQ_HZ) * longint'(TICK_US)) / 64'd1_000_000;
  localparam int unsigned TICK_CYCLES = (TICK_RAW == 0) ? 1 : int'(TICK_RAW);

  nw_kind_e         kind;
  logic [CFG_W-1:0] dec_units;
  logic [CFG_W-1:0] units_q;
  logic [CFG_W-1:0] load_val;
  logic             load;
  logic             restart;
  logic             presc_clear;
  logic             running;
  logic             tick;
  logic             last_unit;
  nw_state_e        state_q;
  nw_state_e        state_d;

  nw_cfg_decode #(
    .CFG_W     (CFG_W),
    .MAX_UNITS (MAX_UNITS)
  ) u_decode (
    .cfg_val (cfg_val_i),
    .cfg_inv (cfg_inv_i),
    .kind    (kind),
    .units   (dec_units)
  );

  assign running     = (state_q == ST_RUN);
  assign restart     = running && !start_i && !unlock_i && activity_i;
  assign presc_clear = start_i || restart;
  assign load        = (start_i && (kind == CFG_FINITE)) || restart;
  assign load_val    = start_i ? dec_units : units_q;

  nw_prescaler #(
    .TICK_CYCLES (TICK_CYCLES)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (presc_clear),
    .run   (running),
    .tick  (tick)
  );

  nw_unit_counter #(
    .CFG_W (CFG_W)
  ) u_units (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_val  (load_val),
    .dec       (tick),
    .last_unit (last_unit)
  );

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      unique case (kind)
        CFG_CLOSED:  state_d = ST_EXPIRED;
        CFG_FINITE:  state_d = ST_RUN;
        default:     state_d = ST_FOREVER;
      endcase
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (unlock_i)                state_d = ST_UNLOCKED;
          else if (activity_i)         state_d = ST_RUN;
          else if (tick && last_unit)  state_d = ST_EXPIRED;
        end
        ST_FOREVER: begin
          if (unlock_i) state_d = ST_UNLOCKED;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      units_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_i && (kind == CFG_FINITE)) begin
        units_q <= dec_units;
      end
    end
  end

  assign timeout_o      = (state_q == ST_EXPIRED);
  assign window_open_o  = (state_q == ST_RUN) || (state_q == ST_FOREVER) ||
                          (state_q == ST_UNLOCKED);
  assign wait_forever_o = (state_q == ST_FOREVER);
  assign wdog_hold_o    = (state_q == ST_UNLOCKED);

endmodule

// File: rtl/nw_window_checker.sv
module nw_window_checker #(
  parameter int unsigned CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [CFG_W-1:0] cfg_val_i,
  input logic [CFG_W-1:0] cfg_inv_i,
  input logic             unlock_i,
  input logic             activity_i,
  input logic             timeout_o,
  input logic             window_open_o,
  input logic             wait_forever_o,
  input logic             wdog_hold_o
);

  // R3: a closed window expires on the first edge after start
  p_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (cfg_val_i == '0) && (cfg_inv_i == '1) |=> timeout_o && !window_open_o);

  // R4: all-ones keeps waiting
  p_forever_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (cfg_val_i == '1) && (cfg_inv_i == '0) |=> wait_forever_o && window_open_o && !timeout_o);

  // R5: an invalid pair falls back to waiting forever
  p_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (cfg_val_i != ~cfg_inv_i) |=> wait_forever_o && !timeout_o);

  // R6: unlock while open freezes the window
  p_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    window_open_o && unlock_i && !start_i |=> wdog_hold_o && window_open_o && !timeout_o);

  // R6: a frozen window stays frozen until restarted
  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_hold_o && !start_i |=> wdog_hold_o);

  // R7: activity after expiry has no effect
  p_act_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o && activity_i && !start_i |=> timeout_o);

  // R9: timeout is sticky until the next start
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o && !start_i |=> timeout_o);

  // R9: expired and open never coincide
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout_o && window_open_o));

endmodule

bind nw_window_timer nw_window_checker #(.CFG_W(CFG_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .cfg_val_i      (cfg_val_i),
  .cfg_inv_i      (cfg_inv_i),
  .unlock_i       (unlock_i),
  .activity_i     (activity_i),
  .timeout_o      (timeout_o),
  .window_open_o  (window_open_o),
  .wait_forever_o (wait_forever_o),
  .wdog_hold_o    (wdog_hold_o)
);

// File: tb/test_nw_window_timer.sv
module test_nw_window_timer;

  localparam int CLK_PERIOD = 10;
  localparam int HZ         = 1000;
  localparam int TUS        = 5000;
  localparam int T          = HZ * TUS / 1000000;
  localparam int CAP_A      = 28;
  localparam int CAP_B      = 254;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] cfg_val_i = 8'h00;
  logic [7:0] cfg_inv_i = 8'hFF;
  logic       unlock_i = 1'b0;
  logic       activity_i = 1'b0;
  logic       timeout_o, window_open_o, wait_forever_o, wdog_hold_o;
  logic       to_b, open_b, fe_b, hold_b;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nw_window_timer #(.CLK_FREQ_HZ(HZ), .TICK_US(TUS), .CFG_W(8), .MAX_UNITS(CAP_A)) i_nw_window_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_val_i(cfg_val_i), .cfg_inv_i(cfg_inv_i),
    .unlock_i(unlock_i), .activity_i(activity_i), .timeout_o(timeout_o),
    .window_open_o(window_open_o), .wait_forever_o(wait_forever_o), .wdog_hold_o(wdog_hold_o));

  nw_window_timer #(.CLK_FREQ_HZ(HZ), .TICK_US(TUS), .CFG_W(8), .MAX_UNITS(CAP_B)) i_nw_interframe (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_val_i(cfg_val_i), .cfg_inv_i(cfg_inv_i),
    .unlock_i(unlock_i), .activity_i(activity_i), .timeout_o(to_b),
    .window_open_o(open_b), .wait_forever_o(fe_b), .wdog_hold_o(hold_b));

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic kick(input logic [7:0] v, input logic [7:0] inv);
    cfg_val_i = v;
    cfg_inv_i = inv;
    start_i   = 1'b1;
    step();
    start_i   = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    step(3);
    // R9: reset state
    chk("R9 reset timeout", timeout_o, 1'b0);
    chk("R9 reset open", window_open_o, 1'b0);
    chk("R9 reset forever", wait_forever_o, 1'b0);
    chk("R9 reset hold", wdog_hold_o, 1'b0);
    rst_n = 1'b1;
    step(2);

    // R1 R2 R3 R4: sweep every valid byte
    for (int v = 0; v < 256; v++) begin
      int n;
      kick(8'(v), ~8'(v));
      if (v == 0) begin
        chk("R3 closed timeout", timeout_o, 1'b1);
        chk("R3 closed open", window_open_o, 1'b0);
      end else if (v == 255) begin
        chk("R4 forever flag", wait_forever_o, 1'b1);
        chk("R4 forever open", window_open_o, 1'b1);
        step(150);
        chk("R4 no timeout", timeout_o, 1'b0);
      end else begin
        n = (v > CAP_A) ? CAP_A : v;
        chk("R1 open at start", window_open_o, 1'b1);
        step(n * T - 1);
        chk((v > CAP_A) ? "R2 clamp before" : "R1 before expiry", timeout_o, 1'b0);
        step();
        chk((v > CAP_A) ? "R2 clamp expiry" : "R1 at expiry", timeout_o, 1'b1);
        chk("R1 closed after", window_open_o, 1'b0);
      end
    end

    // R9: sticky timeout
    kick(8'h01, 8'hFE);
    step(T + 40);
    chk("R9 sticky", timeout_o, 1'b1);

    // R5: invalid pairs behave like 8'hFF
    kick(8'h05, 8'h00);
    chk("R5 invalid forever", wait_forever_o, 1'b1);
    step(100);
    chk("R5 invalid no timeout", timeout_o, 1'b0);
    kick(8'h00, 8'h00);
    chk("R5 invalid zero forever", wait_forever_o, 1'b1);
    chk("R5 invalid zero no timeout", timeout_o, 1'b0);

    // R6: unlock mid window
    kick(8'd10, ~8'd10);
    step(20);
    unlock_i = 1'b1; step(); unlock_i = 1'b0;
    chk("R6 hold", wdog_hold_o, 1'b1);
    step(200);
    chk("R6 no timeout", timeout_o, 1'b0);
    chk("R6 still open", window_open_o, 1'b1);
    // R6: unlock from forever
    kick(8'hFF, 8'h00);
    unlock_i = 1'b1; step(); unlock_i = 1'b0;
    chk("R6 forever hold", wdog_hold_o, 1'b1);
    chk("R6 forever flag drops", wait_forever_o, 1'b0);
    // R8: restart from frozen
    kick(8'd2, ~8'd2);
    chk("R8 hold cleared", wdog_hold_o, 1'b0);
    step(2 * T - 1);
    chk("R8 before expiry", timeout_o, 1'b0);
    step();
    chk("R8 at expiry", timeout_o, 1'b1);
    // R6: unlock after expiry ignored
    unlock_i = 1'b1; step(); unlock_i = 1'b0;
    chk("R6 late unlock timeout", timeout_o, 1'b1);
    chk("R6 late unlock hold", wdog_hold_o, 1'b0);

    // R7: activity restarts
    kick(8'd4, ~8'd4);
    step(12);
    activity_i = 1'b1; step(); activity_i = 1'b0;
    step(4 * T - 1);
    chk("R7 restarted before", timeout_o, 1'b0);
    step();
    chk("R7 restarted expiry", timeout_o, 1'b1);
    activity_i = 1'b1; step(); activity_i = 1'b0;
    chk("R7 late activity", timeout_o, 1'b1);
    // R7: unlock beats activity
    kick(8'd3, ~8'd3);
    unlock_i = 1'b1; activity_i = 1'b1; step(); unlock_i = 1'b0; activity_i = 1'b0;
    chk("R7 unlock priority", wdog_hold_o, 1'b1);

    // R8: start mid window clears prescaler
    kick(8'd3, ~8'd3);
    step(7);
    kick(8'd1, ~8'd1);
    step(T - 1);
    chk("R8 restart before", timeout_o, 1'b0);
    step();
    chk("R8 restart expiry", timeout_o, 1'b1);

    // R10: interframe instance and clamp on the narrow one
    kick(8'h38, ~8'h38);
    step(CAP_A * T);
    chk("R10 narrow clamps 0x38", timeout_o, 1'b1);
    chk("R10 wide still open", open_b, 1'b1);
    step(56 * T - CAP_A * T - 1);
    chk("R10 wide before 280", to_b, 1'b0);
    step();
    chk("R10 wide at 280", to_b, 1'b1);
    kick(8'h80, ~8'h80);
    step(128 * T - 1);
    chk("R10 wide 0x80 before", to_b, 1'b0);
    step();
    chk("R10 wide 0x80 expiry", to_b, 1'b1);
    chk("R10 wide no hold", hold_b | fe_b, 1'b0);

    finish_run();
  end

endmodule